// File: doc/BRIEF.md
# Dithered Multi-Channel PWM Generator

This block drives five output pins with pulse-width modulation. It reaches 8-bit duty resolution while its period is only 32 PWM clocks long. Each channel's 8-bit duty byte has two parts. The upper five bits are a coarse high time. The lower three bits are a dither count, which lengthens the high time by one extra PWM clock in a chosen subset of the eight periods that make up a frame. Averaged over a frame, the output therefore carries the fractional part of the duty value. The repetition rate stays that of a 5-bit counter.

A shared prescaler derives the PWM clock from the system clock. One 5-bit step counter and one 3-bit frame counter serve all channels. Duty bytes written by the host are staged and applied together at the next frame start, so no period is ever built from half of an old value and half of a new one. A per-channel enable chooses, for each pin, between the PWM waveform and an ordinary port latch bit.

Top module: `dither_pwm`

## Requirements
- R1: Register writes take effect when `wr_en` is 1 at a clock edge, with the target chosen by `wr_addr`:
  - Addresses 0 to 4 load the duty byte of channel 0 to 4.
  - Address 5 loads the enable mask, where bit i belongs to channel i.
  - Address 6 loads the 2-bit divider select from `wr_data[1:0]`.
- R2: One PWM clock lasts 2^(div+1) system clocks, which gives a divide by 2, 4, 8 or 16. One PWM period is 32 PWM clocks.
- R3: In every period, an enabled channel's pin is high for the first C PWM clocks and low for the rest, where C is the duty byte's bits [7:3].
- R4: When a period is stretched, the pin stays high for exactly one more PWM clock, directly after the coarse high time. A frame is eight periods indexed 0 to 7. Dither bit 2 (byte bit 2) stretches the odd indices. Dither bit 1 stretches indices 2 and 6. Dither bit 0 stretches index 4. Index 0 is never stretched.
- R5: The number of stretched periods in a frame equals the 3-bit dither count.
- R6: A duty byte of 00h gives a constant low pin. A coarse value of 31 in a stretched period gives a pin that is high for the whole period.
- R7: A duty byte written to a channel has no effect on that channel's pin until the next frame begins. A write made in the middle of a frame leaves the rest of that frame unchanged.
- R8: A channel whose enable bit is 0 drives its `port_latch` bit onto its pin. The enable mask acts at once.
- R9: Reset clears all duty bytes, the enable mask, the divider select and the counters. After reset every pin follows `port_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0-4 duty, 5 enable, 6 divider) |
| wr_data | input | 8 | Write data |
| port_latch | input | 5 | Port values for channels in port mode |
| pin_out | output | 5 | Pin drive, PWM or port value per channel |

## Verification
The bench builds the block with its default parameters: five channels, a 5-bit coarse field, a 3-bit dither field and a 2-bit divider select. It runs cases with divider settings of 0, 1 and 3. These make PWM clocks of 2, 4 and 16 system clocks, so the exact high time of every period and the exact period length can be measured as counts of system clocks. Across the eight periods of a frame, the duty bytes cover every dither bit, the zero-duty byte, full coarse with stretch, and coarse zero with dither only. A duty write made in the middle of a frame, and disabled channels with high and low latch values, show the staging behaviour and the pin multiplexing at the pins.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
    localparam int unsigned CH_MAX    = 5;
    localparam int unsigned COARSE_W  = 5;
    localparam int unsigned DITHER_W  = 3;
    localparam int unsigned DUTY_W    = COARSE_W + DITHER_W;
    localparam int unsigned DIVSEL_W  = 2;
    localparam int unsigned ADDR_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 3'd5,
        REG_DIVIDE = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [DITHER_W-1:0] dither;
    } duty_t;
endpackage

// File: rtl/dpwm_prescaler.sv
module dpwm_prescaler #(
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int unsigned CNT_W = (1 << DIV_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_st_t;

    pre_st_t        st_d, st_q;
    logic [DIV_W:0] shamt;
    logic [CNT_W:0] limit;

    always_comb begin
        st_d  = st_q;
        shamt = {1'b0, div_sel} + 1'b1;
        limit = ({{CNT_W{1'b0}}, 1'b1} << shamt) - 1'b1;
        tick  = ({1'b0, st_q.cnt} >= limit);
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the PWM clock is at least two system clocks long
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
    parameter int unsigned STEP_W  = 5,
    parameter int unsigned FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic [STEP_W-1:0]  step,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_wrap
);
    typedef struct packed {
        logic [STEP_W-1:0]  step;
        logic [FRAME_W-1:0] frame;
    } tb_st_t;

    tb_st_t st_d, st_q;
    logic   last_step;

    always_comb begin
        st_d       = st_q;
        last_step  = &st_q.step;
        frame_wrap = tick && last_step && (&st_q.frame);
        if (tick) begin
            st_d.step = st_q.step + 1'b1;
            if (last_step) st_d.frame = st_q.frame + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step  = st_q.step;
    assign frame = st_q.frame;

    // R2: the step counter advances only on PWM clock ticks
    assert_step_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(st_q.step));
    // R4: the frame index advances when a period ends
    assert_frame_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && last_step) |=> (st_q.frame == FRAME_W'($past(st_q.frame) + 1'b1)));
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel
    import dpwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [DUTY_W-1:0]   wr_data,
    input  logic                frame_wrap,
    input  logic [COARSE_W-1:0] step,
    input  logic [DITHER_W-1:0] frame,
    input  logic                enable,
    input  logic                latch,
    output logic                pin
);
    typedef struct packed {
        duty_t staged;
        duty_t active;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   stretch;
    logic   pwm_bit;

    // Spread the dither evenly: the bit of weight 2^k owns the frame indices
    // whose lowest set bit sits at position DITHER_W-1-k.
    function automatic logic stretch_hit(input logic [DITHER_W-1:0] cnt,
                                         input logic [DITHER_W-1:0] idx);
        logic hit;
        logic found;
        hit   = 1'b0;
        found = 1'b0;
        for (int b = 0; b < DITHER_W; b++) begin
            if (!found && idx[b]) begin
                found = 1'b1;
                hit   = cnt[DITHER_W-1-b];
            end
        end
        return hit;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_stb) st_d.staged = duty_t'(wr_data);
        if (frame_wrap) st_d.active = wr_stb ? duty_t'(wr_data) : st_q.staged;
        stretch = stretch_hit(st_q.active.dither, frame);
        pwm_bit = (step < st_q.active.coarse) ||
                  ((step == st_q.active.coarse) && stretch);
        pin     = enable ? pwm_bit : latch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: no high output past the coarse time plus one stretch step
    assert_low_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step > st_q.active.coarse) |-> !pwm_bit);
    // R6: an all-zero duty byte keeps the waveform low
    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active == '0) |-> !pwm_bit);
    // R7: the applied duty changes only at a frame start
    assert_frame_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_wrap |=> $stable(st_q.active));
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
    import dpwm_pkg::*;
#(
    parameter int unsigned NUM_CH = CH_MAX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DUTY_W-1:0]   wr_data,
    input  logic [NUM_CH-1:0]   port_latch,
    output logic [NUM_CH-1:0]   pin_out
);
    typedef struct packed {
        logic [NUM_CH-1:0]   en;
        logic [DIVSEL_W-1:0] div;
    } cfg_st_t;

    cfg_st_t             cfg_d, cfg_q;
    logic                tick;
    logic                frame_wrap;
    logic [COARSE_W-1:0] step;
    logic [DITHER_W-1:0] frame;
    logic [NUM_CH-1:0]   duty_stb;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_addr == REG_ENABLE) cfg_d.en  = wr_data[NUM_CH-1:0];
        if (wr_en && wr_addr == REG_DIVIDE) cfg_d.div = wr_data[DIVSEL_W-1:0];
        for (int i = 0; i < NUM_CH; i++)
            duty_stb[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    dpwm_prescaler #(.DIV_W(DIVSEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(cfg_q.div), .tick(tick)
    );

    dpwm_timebase #(.STEP_W(COARSE_W), .FRAME_W(DITHER_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .step(step), .frame(frame), .frame_wrap(frame_wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dpwm_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_stb(duty_stb[g]), .wr_data(wr_data),
            .frame_wrap(frame_wrap), .step(step), .frame(frame),
            .enable(cfg_q.en[g]), .latch(port_latch[g]),
            .pin(pin_out[g])
        );
    end

    // R1: at most one duty register is written per cycle
    assert_single_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(duty_stb));
    // R8: a disabled channel mirrors its latch bit
    assert_port_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en[0] |-> (pin_out[0] == port_latch[0]));
endmodule

// File: tb/dither_pwm_test.sv
module dither_pwm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [4:0] port_latch = '0;
    logic [4:0] pin_out;

    always #2 clk = ~clk;

    dither_pwm uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .port_latch(port_latch), .pin_out(pin_out)
    );

    typedef struct { int ch; int per; int cnt; } exp_t;
    exp_t exp_q[$];

    int  errors = 0;
    int  checks = 0;
    int  cur_p  = 2;
    bit  meas_req = 0, meas_started = 0, meas_done = 0, finished = 0;

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int stretched(input int f, input logic [2:0] dth);
        if (f % 2 == 1) return int'(dth[2]);
        if (f == 2 || f == 6) return int'(dth[1]);
        if (f == 4) return int'(dth[0]);
        return 0;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Driver: configure, push expected high counts, start the monitor.
    task automatic run_case(input logic [1:0] dv, input logic [4:0][7:0] dat,
                            input logic [4:0] en, input logic [4:0] lat,
                            input bit midwrite);
        rst_n = 1'b0;
        port_latch = lat;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R9 reset pins follow latch", int'(pin_out), int'(lat));
        cur_p = 1 << (dv + 1);
        wr(3'd6, {6'd0, dv});
        wr(3'd5, {3'd0, en});
        for (int c = 0; c < 5; c++) wr(3'(c), dat[c]);
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: written duty bytes are not applied before the next frame
        check("R7 staged duty not yet applied", int'(pin_out & en), 0);
        for (int f = 0; f < 8; f++)
            for (int c = 0; c < 5; c++) begin
                exp_t e;
                e.ch = c; e.per = f;
                if (en[c]) e.cnt = (int'(dat[c][7:3]) + stretched(f, dat[c][2:0])) * cur_p;
                else       e.cnt = lat[c] ? 32 * cur_p : 0;
                exp_q.push_back(e);
            end
        meas_started = 0; meas_done = 0; meas_req = 1;
        if (midwrite) begin
            wait (meas_started);
            repeat (40) @(posedge clk);
            wr(3'd1, 8'hF8);
        end
        wait (meas_done);
    endtask

    // Monitor: align on channel 0's first rising edge, integrate each period.
    initial begin
        forever begin
            int hi [5];
            bit prev0;
            wait (meas_req);
            prev0 = 1'b1;
            forever begin
                @(negedge clk);
                if (pin_out[0] && !prev0) break;
                prev0 = pin_out[0];
            end
            meas_started = 1;
            for (int per = 0; per < 8; per++) begin
                for (int c = 0; c < 5; c++) hi[c] = 0;
                for (int s = 0; s < 32 * cur_p; s++) begin
                    if (!(per == 0 && s == 0)) @(negedge clk);
                    if (s == 0)
                        check("R2 period starts high on ch0", int'(pin_out[0]), 1);
                    if (s == 32 * cur_p - 1)
                        check("R2 period ends low on ch0", int'(pin_out[0]), 0);
                    for (int c = 0; c < 5; c++) hi[c] += int'(pin_out[c]);
                end
                for (int c = 0; c < 5; c++) begin
                    exp_t e;
                    if (exp_q.size() == 0) begin
                        check("R3 expected item missing", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        // R3 R4 R5 R6 R8: high time per channel per period
                        check($sformatf("R4 ch%0d period%0d high cycles", e.ch, e.per),
                              hi[c], e.cnt);
                    end
                end
            end
            meas_req = 0;
            meas_done = 1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 R3 R4 R6 R7 R8: divide by 2, dither patterns, mid-frame write on ch1
        run_case(2'd0, {8'h55, 8'h07, 8'hFF, 8'h00, 8'h83}, 5'b01111, 5'b10000, 1'b1);
        // R2 R5: divide by 16, single-bit and full coarse
        run_case(2'd3, {8'h21, 8'h10, 8'hF9, 8'h42, 8'h0C}, 5'b11111, 5'b00000, 1'b0);
        // R8: divide by 4, ch1 disabled with latch low
        run_case(2'd1, {8'h7F, 8'h05, 8'h06, 8'h03, 8'hF0}, 5'b11101, 5'b00000, 1'b0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule